// File: doc/BRIEF.md
# Attenuation Mode and Power-Up Controller

This block decides which attenuation code drives a digital step attenuator core. A mode input picks the source: with it low the code comes from a 7-bit pin bus, and with it high the code comes from the attenuation field of a serial word. The serial word is assembled and address-checked by separate shift logic. In pin mode a strobe input sets the behaviour. While the strobe is high the code follows the pins, as a transparent latch. While it is low the last code is held. Holding the strobe high permanently gives direct operation, and pulsing it gives latched operation. In serial mode, a rising strobe transfers the serial word's attenuation field to the core.

After reset the block waits for its input synchronizers to fill. It then samples the mode and strobe once to classify the power-up mode. In serial and latched modes the core stays at maximum attenuation until the first transfer. In direct mode it stays at maximum for a programmable hold time and then follows the pins. A sticky flag reports a breach of the one-time sequencing rule. That rule requires that the top bit of the serial word has been loaded low serially before pin mode is entered, and that the pins stay low while serial mode is used before that first load.

Top module: `atten_mode_ctl`

## Requirements
- R1: While reset is asserted and until the power-up mode has been classified, `att_code` is all ones (127, i.e. 31.75 dB) and `seq_fault` is 0.
- R2: When powering up in latched pin mode (`mode_serial`=0 and `load_strobe`=0 at reset release), `att_code` stays 127 whatever `pin_code` does, until `load_strobe` is raised.
- R3: In pin mode with `load_strobe` high (and no power-up hold running), `att_code` equals `pin_code` SYNC_STAGES+1 clock edges after the pins change.
- R4: In pin mode with `load_strobe` low, `att_code` keeps the value it had when the strobe fell, and changes on `pin_code` are ignored.
- R5: When powering up in direct pin mode (`mode_serial`=0 and `load_strobe`=1 at reset release), `att_code` stays 127 for PUP_DELAY_CYC cycles after classification and then follows `pin_code`.
- R6: In serial mode, a rising edge of `load_strobe` loads `shift_word[6:0]` into `att_code`. Changes of `shift_word` without such an edge are ignored, and `shift_word[7]` is never applied.
- R7: When powering up in serial mode, `att_code` stays 127 until the first serial load.
- R8: `seq_fault` rises when the mode switches from serial to pin mode before any serial load with `shift_word[7]`=0 has occurred, or while the most recently loaded `shift_word[7]` is 1.
- R9: `seq_fault` rises when any `pin_code` bit is 1 while in serial mode before the first serial load with `shift_word[7]`=0.
- R10: `seq_fault` is sticky until reset. After a serial load with `shift_word[7]`=0, switches between the modes that respect R8 and R9 leave it at 0.
- R11: The code is binary in quarter-dB units: bit i of `att_code` weighs 0.25·2^i dB, so bit 6 is 16 dB, bit 0 is 0.25 dB, and 0 is the insertion-loss state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| mode_serial | input | 1 | 0 selects pin source, 1 selects serial source |
| load_strobe | input | 1 | Transfer strobe: transparent in pin mode, rising edge loads in serial mode |
| pin_code | input | ATT_W | Parallel attenuation pins, quarter-dB binary |
| shift_word | input | ATT_W+1 | Serial register attenuation word; top bit must be loaded low |
| att_code | output | ATT_W | Attenuation code driving the core |
| seq_fault | output | 1 | Sticky sequencing-violation flag |

## Verification
The bench builds the block with SYNC_STAGES=2 and PUP_DELAY_CYC=20. This keeps the latency at three edges and makes the direct power-up hold short enough to watch end to end. With those values every one of the 128 pin codes is swept in both the transparent and the holding phase of the strobe, and every one of the 256 serial words is offered both without and with a load edge. Separate resets into each of the three power-up modes reach the hold behaviour and the fault paths, including a loaded top bit of 1 before entering pin mode.

// File: rtl/atten_ctl_pkg.sv
`timescale 1ns/1ps
package atten_ctl_pkg;

   typedef enum logic [1:0] {
      BOOT_SERIAL  = 2'd0,
      BOOT_LATCHED = 2'd1,
      BOOT_DIRECT  = 2'd2
   } boot_mode_e;

   function automatic boot_mode_e classify_boot(input logic serial_sel, input logic strobe);
      if (serial_sel)
         return BOOT_SERIAL;
      else if (strobe)
         return BOOT_DIRECT;
      else
         return BOOT_LATCHED;
   endfunction

endpackage

// File: rtl/atten_pin_sync.sv
`timescale 1ns/1ps
module atten_pin_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_flops
         logic [STAGES-1:0][W-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe <= '0;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++)
                  pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/atten_boot_seq.sv
`timescale 1ns/1ps
module atten_boot_seq
   import atten_ctl_pkg::*;
#(
   parameter int SETTLE_CYC    = 3,
   parameter int PUP_DELAY_CYC = 40000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       serial_sel,
   input  logic       strobe,
   output logic       boot_done,
   output boot_mode_e boot_mode,
   output logic       pup_hold
);

   localparam int SW = $clog2(SETTLE_CYC + 1);
   localparam int DW = $clog2(PUP_DELAY_CYC + 1);

   logic [SW-1:0] settle_cnt;
   logic [DW-1:0] dly_cnt;
   logic          dly_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         settle_cnt <= '0;
         boot_done  <= 1'b0;
         boot_mode  <= BOOT_LATCHED;
      end else if (!boot_done) begin
         if (settle_cnt == SW'(SETTLE_CYC - 1)) begin
            boot_done <= 1'b1;
            boot_mode <= classify_boot(serial_sel, strobe);
         end else begin
            settle_cnt <= settle_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_cnt  <= '0;
         dly_done <= 1'b0;
      end else if (boot_done && boot_mode == BOOT_DIRECT && !dly_done) begin
         if (dly_cnt == DW'(PUP_DELAY_CYC - 1))
            dly_done <= 1'b1;
         else
            dly_cnt <= dly_cnt + 1'b1;
      end
   end

   assign pup_hold = boot_done && (boot_mode == BOOT_DIRECT) && !dly_done;

endmodule

// File: rtl/atten_state_sel.sv
`timescale 1ns/1ps
module atten_state_sel #(
   parameter int ATT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boot_done,
   input  logic             pup_hold,
   input  logic             serial_sel,
   input  logic             strobe,
   input  logic             ser_load,
   input  logic [ATT_W-1:0] pins,
   input  logic [ATT_W-1:0] ser_att,
   output logic [ATT_W-1:0] state
);

   localparam logic [ATT_W-1:0] ATT_MAX = {ATT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ATT_MAX;
      end else if (!boot_done || pup_hold) begin
         state <= ATT_MAX;
      end else if (serial_sel) begin
         if (ser_load)
            state <= ser_att;
      end else if (strobe) begin
         state <= pins;
      end
   end

endmodule

// File: rtl/atten_seq_guard.sv
`timescale 1ns/1ps
module atten_seq_guard #(
   parameter int ATT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boot_done,
   input  logic             serial_sel,
   input  logic             ser_load,
   input  logic             to_pin_mode,
   input  logic [ATT_W-1:0] pins,
   input  logic             ser_top,
   output logic             seq_done,
   output logic             fault
);

   logic top_stored;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_stored <= 1'b1;
         seq_done   <= 1'b0;
      end else if (ser_load) begin
         top_stored <= ser_top;
         if (!ser_top)
            seq_done <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault <= 1'b0;
      end else begin
         if (to_pin_mode && (!seq_done || top_stored))
            fault <= 1'b1;
         if (boot_done && serial_sel && !seq_done && (pins != '0))
            fault <= 1'b1;
      end
   end

endmodule

// File: rtl/atten_mode_ctl.sv
`timescale 1ns/1ps
module atten_mode_ctl
   import atten_ctl_pkg::*;
#(
   parameter int ATT_W         = 7,
   parameter int SYNC_STAGES   = 2,
   parameter int PUP_DELAY_CYC = 40000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_serial,
   input  logic             load_strobe,
   input  logic [ATT_W-1:0] pin_code,
   input  logic [ATT_W:0]   shift_word,
   output logic [ATT_W-1:0] att_code,
   output logic             seq_fault
);

   localparam int WORD_W     = ATT_W + 1;
   localparam int BUS_W      = 2 + ATT_W + WORD_W;
   localparam int SETTLE_CYC = SYNC_STAGES + 1;

   generate
      if (ATT_W < 1 || ATT_W > 12) begin : g_bad_width
         $error("atten_mode_ctl: ATT_W must be 1..12");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("atten_mode_ctl: SYNC_STAGES must be 0..4");
      end
      if (PUP_DELAY_CYC < 1) begin : g_bad_delay
         $error("atten_mode_ctl: PUP_DELAY_CYC must be at least 1");
      end
   endgenerate

   logic [BUS_W-1:0]  raw_bus;
   logic [BUS_W-1:0]  sync_bus;
   logic              ps_s;
   logic              le_s;
   logic [ATT_W-1:0]  pins_s;
   logic [WORD_W-1:0] ser_s;
   logic              le_prev;
   logic              ps_prev;
   logic              boot_done;
   boot_mode_e        boot_mode;
   logic              pup_hold;
   logic              ser_load;
   logic              to_pin_mode;
   logic              seq_done;

   assign raw_bus = {mode_serial, load_strobe, pin_code, shift_word};

   atten_pin_sync #(
      .W      (BUS_W),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_bus),
      .q     (sync_bus)
   );

   assign ps_s   = sync_bus[BUS_W-1];
   assign le_s   = sync_bus[BUS_W-2];
   assign pins_s = sync_bus[BUS_W-3 -: ATT_W];
   assign ser_s  = sync_bus[WORD_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         le_prev <= 1'b0;
         ps_prev <= 1'b0;
      end else begin
         le_prev <= le_s;
         ps_prev <= ps_s;
      end
   end

   assign ser_load    = boot_done && ps_s && le_s && !le_prev;
   assign to_pin_mode = boot_done && !ps_s && ps_prev;

   atten_boot_seq #(
      .SETTLE_CYC    (SETTLE_CYC),
      .PUP_DELAY_CYC (PUP_DELAY_CYC)
   ) i_boot (
      .clk        (clk),
      .rst_n      (rst_n),
      .serial_sel (ps_s),
      .strobe     (le_s),
      .boot_done  (boot_done),
      .boot_mode  (boot_mode),
      .pup_hold   (pup_hold)
   );

   atten_state_sel #(
      .ATT_W (ATT_W)
   ) i_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .boot_done  (boot_done),
      .pup_hold   (pup_hold),
      .serial_sel (ps_s),
      .strobe     (le_s),
      .ser_load   (ser_load),
      .pins       (pins_s),
      .ser_att    (ser_s[ATT_W-1:0]),
      .state      (att_code)
   );

   atten_seq_guard #(
      .ATT_W (ATT_W)
   ) i_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .boot_done   (boot_done),
      .serial_sel  (ps_s),
      .ser_load    (ser_load),
      .to_pin_mode (to_pin_mode),
      .pins        (pins_s),
      .ser_top     (ser_s[WORD_W-1]),
      .seq_done    (seq_done),
      .fault       (seq_fault)
   );

endmodule

// File: rtl/atten_mode_ctl_chk.sv
`timescale 1ns/1ps
module atten_mode_ctl_chk #(
   parameter int ATT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ps_s,
   input logic             le_s,
   input logic             ps_prev,
   input logic             le_prev,
   input logic [ATT_W-1:0] pins_s,
   input logic [ATT_W:0]   ser_s,
   input logic             boot_done,
   input logic             pup_hold,
   input logic             seq_done,
   input logic [ATT_W-1:0] att_code,
   input logic             seq_fault
);

   localparam logic [ATT_W-1:0] ATT_MAX = {ATT_W{1'b1}};

   assert_max_before_boot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_done |-> att_code == ATT_MAX);

   assert_follow_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done && !pup_hold && !ps_s && le_s) |=> att_code == $past(pins_s));

   assert_hold_strobe_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done && !pup_hold && !ps_s && !le_s) |=> $stable(att_code));

   assert_direct_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pup_hold |=> att_code == ATT_MAX);

   assert_serial_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done && !pup_hold && ps_s && le_s && !le_prev) |=> att_code == $past(ser_s[ATT_W-1:0]));

   assert_serial_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done && !pup_hold && ps_s && !(le_s && !le_prev)) |=> $stable(att_code));

   assert_unseq_pin_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done && !ps_s && ps_prev && !seq_done) |=> seq_fault);

   assert_pins_in_serial_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done && ps_s && !seq_done && pins_s != '0) |=> seq_fault);

   assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      seq_fault |=> seq_fault);

endmodule

bind atten_mode_ctl atten_mode_ctl_chk #(.ATT_W(ATT_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ps_s      (ps_s),
   .le_s      (le_s),
   .ps_prev   (ps_prev),
   .le_prev   (le_prev),
   .pins_s    (pins_s),
   .ser_s     (ser_s),
   .boot_done (boot_done),
   .pup_hold  (pup_hold),
   .seq_done  (seq_done),
   .att_code  (att_code),
   .seq_fault (seq_fault)
);

// File: tb/test_atten_mode_ctl.sv
`timescale 1ns/1ps
module test_atten_mode_ctl;

   localparam int ATT_W = 7;
   localparam int SYNC  = 2;
   localparam int DLY   = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mode_serial = 1'b0;
   logic             load_strobe = 1'b0;
   logic [ATT_W-1:0] pin_code = '0;
   logic [ATT_W:0]   shift_word = '0;
   logic [ATT_W-1:0] att_code;
   logic             seq_fault;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   atten_mode_ctl #(
      .ATT_W         (ATT_W),
      .SYNC_STAGES   (SYNC),
      .PUP_DELAY_CYC (DLY)
   ) i_atten_mode_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_serial (mode_serial),
      .load_strobe (load_strobe),
      .pin_code    (pin_code),
      .shift_word  (shift_word),
      .att_code    (att_code),
      .seq_fault   (seq_fault)
   );

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // quarter-dB value from bit weights (R11)
   function automatic int quarters(input logic [ATT_W-1:0] c);
      int q = 0;
      for (int i = 0; i < ATT_W; i++)
         if (c[i]) q += (1 << i);
      return q;
   endfunction

   task automatic power_up(input logic ps, input logic le, input logic [ATT_W-1:0] p,
                           input logic [ATT_W:0] w);
      @(negedge clk);
      rst_n = 1'b0;
      mode_serial = ps; load_strobe = le; pin_code = p; shift_word = w;
      cyc(3);
      chk({1'b0, att_code}, 8'd127, "R1 reset code");
      chk({7'd0, seq_fault}, 8'd0, "R1 reset fault");
      rst_n = 1'b1;
   endtask

   task automatic serial_load(input logic [ATT_W:0] w);
      shift_word = w;
      cyc(4);
      load_strobe = 1'b1;
      cyc(5);
      load_strobe = 1'b0;
      cyc(4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [ATT_W-1:0] held;

      // Latched power-up: pins ignored while strobe low (R2)
      power_up(1'b0, 1'b0, 7'd5, 8'd0);
      cyc(10);
      chk({1'b0, att_code}, 8'd127, "R2 latched boot max");
      pin_code = 7'd99;
      cyc(8);
      chk({1'b0, att_code}, 8'd127, "R2 latched boot ignores pins");
      chk({7'd0, seq_fault}, 8'd0, "R10 no fault latched boot");

      // Sweep every pin code: transparent then holding phase (R3, R4, R11)
      for (int v = 0; v < 128; v++) begin
         pin_code = 7'(v);
         load_strobe = 1'b1;
         cyc(SYNC + 2);
         chk(8'(quarters(att_code)), 8'(v), "R3 R11 follow pins");
         load_strobe = 1'b0;
         cyc(SYNC + 2);
         pin_code = ~7'(v);
         cyc(SYNC + 3);
         chk({1'b0, att_code}, 8'(v), "R4 hold while strobe low");
      end

      // Direct power-up hold then follow (R5)
      power_up(1'b0, 1'b1, 7'd37, 8'd0);
      cyc(20);
      chk({1'b0, att_code}, 8'd127, "R5 direct hold");
      cyc(10);
      chk({1'b0, att_code}, 8'd37, "R5 direct after hold");
      for (int v = 0; v < 128; v++) begin
         pin_code = 7'(127 - v);
         cyc(SYNC + 2);
         chk({1'b0, att_code}, 8'(127 - v), "R3 direct follow");
      end
      chk({7'd0, seq_fault}, 8'd0, "R10 no fault direct");

      // Serial power-up (R7) and full word sweep (R6)
      power_up(1'b1, 1'b0, 7'd0, 8'h25);
      cyc(10);
      chk({1'b0, att_code}, 8'd127, "R7 serial boot max");
      load_strobe = 1'b1;
      cyc(5);
      chk({1'b0, att_code}, 8'h25, "R7 first serial load");
      load_strobe = 1'b0;
      cyc(4);
      held = 7'h25;
      for (int w = 0; w < 256; w++) begin
         shift_word = 8'(w);
         cyc(5);
         chk({1'b0, att_code}, {1'b0, held}, "R6 no load without edge");
         load_strobe = 1'b1;
         cyc(5);
         chk({1'b0, att_code}, {1'b0, 7'(w)}, "R6 load drops top bit");
         held = 7'(w);
         load_strobe = 1'b0;
         cyc(3);
      end
      chk({7'd0, seq_fault}, 8'd0, "R10 no fault during serial sweep");

      // Legal switch to pin mode after a top-bit-low load (R10)
      serial_load(8'h10);
      mode_serial = 1'b0;
      cyc(8);
      chk({7'd0, seq_fault}, 8'd0, "R10 legal switch to pin mode");
      chk({1'b0, att_code}, 8'h10, "R4 code kept entering pin mode");
      mode_serial = 1'b1;
      cyc(6);
      serial_load(8'h85);
      chk({1'b0, att_code}, 8'h05, "R6 top bit not applied");
      mode_serial = 1'b0;
      cyc(8);
      chk({7'd0, seq_fault}, 8'd1, "R8 top bit high at pin entry");
      mode_serial = 1'b1;
      cyc(6);
      serial_load(8'h02);
      mode_serial = 1'b0;
      cyc(8);
      chk({7'd0, seq_fault}, 8'd1, "R10 fault sticky");

      // Pin entry without any serial load (R8)
      power_up(1'b1, 1'b0, 7'd0, 8'h00);
      cyc(10);
      mode_serial = 1'b0;
      cyc(8);
      chk({7'd0, seq_fault}, 8'd1, "R8 pin entry unsequenced");

      // Nonzero pins in serial mode before sequencing (R9)
      power_up(1'b0, 1'b0, 7'd3, 8'h00);
      cyc(10);
      mode_serial = 1'b1;
      cyc(8);
      chk({7'd0, seq_fault}, 8'd1, "R9 pins high in serial");

      // Clean sequence from latched boot (R9 negative, R10)
      power_up(1'b0, 1'b0, 7'd0, 8'h00);
      cyc(10);
      mode_serial = 1'b1;
      cyc(6);
      serial_load(8'h05);
      chk({1'b0, att_code}, 8'h05, "R6 serial after latched boot");
      mode_serial = 1'b0;
      cyc(8);
      chk({7'd0, seq_fault}, 8'd0, "R10 clean sequence no fault");
      pin_code = 7'd64;
      load_strobe = 1'b1;
      cyc(6);
      chk(8'(quarters(att_code)), 8'd64, "R11 16 dB bit weight");

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule